// File: doc/BRIEF.md
# Exception Control Unit

This unit sits beside a processor pipeline and owns three system registers: a status word (interrupt mask and a three-level mode/enable stack), a cause word (pending interrupt lines, software interrupt bits, a delay-slot flag and a reason code) and a saved return address. Each cycle it looks at the pipeline's synchronous fault lines and six external interrupt lines and decides whether to enter the handler. On entry it saves the program counter, latches the reason code, pushes the mode/enable stack, and in the following cycle asserts a one-cycle redirect carrying the fixed handler address.

Software reaches the three registers through a read port and a write strobe, both addressed by register number (12 status, 13 cause, 14 saved PC). A return pulse pops the mode/enable stack but leaves the program counter alone, since the handler jumps back on its own.

The control is a two-state machine. `ST_RUN` accepts requests; transition *enter* (RUN to VECTOR) fires when a request is taken. `ST_VECTOR` drives the redirect and ignores all new requests; transition *resume* (VECTOR to RUN) is unconditional after one cycle.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, status, cause and saved PC read as zero, the machine is in `ST_RUN` and `redirect_o` is low.
- R2: When a request is taken at a clock edge, the saved PC (register 14) takes `pc_i` at that edge. During the next cycle only, `redirect_o` is 1 and `redirect_pc_o` is 0x80000080. Otherwise `redirect_pc_o` is 0.
- R3: The cause code sits in cause bits 5..2: 4 for a load address fault, 5 for a store address fault, 12 for overflow, 0 for an interrupt. The priority is load, then store, then overflow, then interrupt. The code changes only when a request is taken.
- R4: On entry, the status stack in bits 5..0 (pairs old 5..4, previous 3..2, current 1..0; in each pair the mode bit is the upper one and the enable bit the lower one) shifts up by one pair, and the current pair becomes 00.
- R5: A return pulse copies previous into current and old into previous, and keeps old. It never raises `redirect_o`.
- R6: An interrupt is taken only if status bit 0 is 1 and some pending source is 1 whose mask bit is also 1. The pending sources are `irq_i` (masked by status bits 15..10) and the software bits (masked by bits 9..8). Cause bits 15..10 show `irq_i` as sampled at the previous edge, and cause bits 9..8 hold the software bits.
- R7: When `in_delay_slot_i` is 1 on entry, cause bit 31 becomes 1 and the saved PC becomes `pc_i` minus 4. Otherwise bit 31 becomes 0.
- R8: Writes go to status bits 15..8 and 5..0, to cause bits 9..8 only, and to the whole saved PC. Unwritable bits and unmapped addresses read 0. Entry discards a write in the same cycle. A return pulse discards a status write in the same cycle.
- R9: In `ST_VECTOR` every request is ignored: no entry, and the code and saved PC are not updated by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | PC of the instruction at the fault point |
| in_delay_slot_i | input | 1 | That instruction sits in a branch delay slot |
| ld_addr_err_i | input | 1 | Load address fault |
| st_addr_err_i | input | 1 | Store address fault |
| ovf_i | input | 1 | Arithmetic overflow |
| irq_i | input | 6 | External interrupt lines |
| exc_return_i | input | 1 | Return-from-handler pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register number for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| redirect_o | output | 1 | Redirect fetch to handler |
| redirect_pc_o | output | 32 | Handler address while redirecting |

## Verification
Directed patterns stress the acceptance decision. All three faults arrive together with an interrupt, which must yield the load code. Partial sets must yield the store and overflow codes. Interrupts on unmasked and masked lines, with the enable bit set and clear, show whether the gate follows the mask-and-enable rule or only one half of it. Same-cycle collisions (entry with a write, return with a status write, a fault during the redirect cycle) separate the three update priorities. A seeded random run mixes all inputs against a bench model, covering stack push/pop chains and software-bit interrupts.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [3:0] {
        CODE_INT  = 4'd0,
        CODE_LDAE = 4'd4,
        CODE_STAE = 4'd5,
        CODE_OVF  = 4'd12
    } exc_code_e;

    typedef enum logic {
        ST_RUN,
        ST_VECTOR
    } ctl_state_e;

    localparam logic [4:0] REG_STATUS = 5'd12;
    localparam logic [4:0] REG_CAUSE  = 5'd13;
    localparam logic [4:0] REG_SAVEPC = 5'd14;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int N_IRQ = 6,
    parameter int N_SW  = 2
) (
    input  logic                    accept_en,
    input  logic                    ld_err_i,
    input  logic                    st_err_i,
    input  logic                    ovf_i,
    input  logic [N_IRQ-1:0]        irq_i,
    input  logic [N_SW-1:0]         sw_i,
    input  logic [N_IRQ+N_SW-1:0]   mask_i,
    input  logic                    ie_i,
    output logic                    take_o,
    output exc_code_e               code_o,
    output logic                    irq_only_o
);
    localparam int SRC_W = N_IRQ + N_SW;

    logic [SRC_W-1:0] src;
    logic [SRC_W-1:0] pend;
    logic             internal;
    logic             int_req;

    assign src = {irq_i, sw_i};

    for (genvar g = 0; g < SRC_W; g++) begin : g_pend
        assign pend[g] = src[g] & mask_i[g];
    end

    assign internal   = ld_err_i | st_err_i | ovf_i;
    assign int_req    = ie_i & (|pend);
    assign take_o     = accept_en & (internal | int_req);
    assign irq_only_o = ~internal & int_req;

    always_comb begin
        if (ld_err_i)      code_o = CODE_LDAE;
        else if (st_err_i) code_o = CODE_STAE;
        else if (ovf_i)    code_o = CODE_OVF;
        else               code_o = CODE_INT;
    end
endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack #(
    parameter int MASK_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_i,
    input  logic                 pop_i,
    input  logic                 wr_i,
    input  logic [MASK_W-1:0]    wmask_i,
    input  logic [2*DEPTH-1:0]   wstack_i,
    output logic [MASK_W-1:0]    mask_o,
    output logic [2*DEPTH-1:0]   stack_o,
    output logic                 ie_o
);
    localparam int SW = 2 * DEPTH;

    logic [MASK_W-1:0] mask_q, mask_d;
    logic [SW-1:0]     stack_q, stack_d;

    always_comb begin
        mask_d  = mask_q;
        stack_d = stack_q;
        if (push_i) begin
            stack_d = {stack_q[SW-3:0], 2'b00};
        end else if (pop_i) begin
            stack_d = {stack_q[SW-1 -: 2], stack_q[SW-1:2]};
        end else if (wr_i) begin
            mask_d  = wmask_i;
            stack_d = wstack_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            stack_q <= '0;
        end else begin
            mask_q  <= mask_d;
            stack_q <= stack_d;
        end
    end

    assign mask_o  = mask_q;
    assign stack_o = stack_q;
    assign ie_o    = stack_q[0];

    assert_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (stack_q[1:0] == 2'b00) && (stack_q[3:2] == $past(stack_q[1:0])));

    assert_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (stack_q[1:0] == $past(stack_q[3:2]))
                               && (stack_q[SW-1 -: 2] == $past(stack_q[SW-1 -: 2])));
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
    import exc_pkg::*;
#(
    parameter int N_IRQ = 6,
    parameter int N_SW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  exc_code_e         code_i,
    input  logic              bd_i,
    input  logic [N_IRQ-1:0]  irq_i,
    input  logic              sw_wr_i,
    input  logic [N_SW-1:0]   sw_wdata_i,
    output logic              bd_o,
    output logic [N_IRQ-1:0]  ip_o,
    output logic [N_SW-1:0]   sw_o,
    output exc_code_e         code_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bd_o   <= 1'b0;
            ip_o   <= '0;
            sw_o   <= '0;
            code_o <= CODE_INT;
        end else begin
            ip_o <= irq_i;
            if (take_i) begin
                bd_o   <= bd_i;
                code_o <= code_i;
            end else if (sw_wr_i) begin
                sw_o <= sw_wdata_i;
            end
        end
    end

    assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (code_o == CODE_INT || code_o == CODE_LDAE
                    || code_o == CODE_STAE || code_o == CODE_OVF));
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          N_IRQ      = 6,
    parameter int          N_SW       = 2,
    parameter int          DEPTH      = 3,
    parameter logic [31:0] HANDLER_PC = 32'h8000_0080
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  pc_i,
    input  logic             in_delay_slot_i,
    input  logic             ld_addr_err_i,
    input  logic             st_addr_err_i,
    input  logic             ovf_i,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic             exc_return_i,
    input  logic             reg_wr_i,
    input  logic [4:0]       reg_addr_i,
    input  logic [XLEN-1:0]  reg_wdata_i,
    output logic [XLEN-1:0]  reg_rdata_o,
    output logic             redirect_o,
    output logic [XLEN-1:0]  redirect_pc_o
);
    localparam int MASK_W  = N_IRQ + N_SW;
    localparam int SW_LSB  = 8;
    localparam int IP_LSB  = SW_LSB + N_SW;
    localparam int STK_W   = 2 * DEPTH;
    localparam int CODE_LSB = 2;

    ctl_state_e        state_q, state_d;
    logic              take, irq_only, ie;
    exc_code_e         arb_code, cur_code;
    logic [MASK_W-1:0] mask;
    logic [STK_W-1:0]  stack;
    logic              bd;
    logic [N_IRQ-1:0]  ip;
    logic [N_SW-1:0]   sw;
    logic [XLEN-1:0]   savepc_q;
    logic              wr_ok, status_wr, cause_wr, savepc_wr;

    // ---- state register ----
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (take) state_d = ST_VECTOR;
            ST_VECTOR: state_d = ST_RUN;
        endcase
    end

    // ---- outputs ----
    always_comb begin
        redirect_o    = 1'b0;
        redirect_pc_o = '0;
        unique case (state_q)
            ST_RUN: ;
            ST_VECTOR: begin
                redirect_o    = 1'b1;
                redirect_pc_o = HANDLER_PC;
            end
        endcase
    end

    exc_arbiter #(.N_IRQ(N_IRQ), .N_SW(N_SW)) arb_i (
        .accept_en  (state_q == ST_RUN),
        .ld_err_i   (ld_addr_err_i),
        .st_err_i   (st_addr_err_i),
        .ovf_i      (ovf_i),
        .irq_i      (irq_i),
        .sw_i       (sw),
        .mask_i     (mask),
        .ie_i       (ie),
        .take_o     (take),
        .code_o     (arb_code),
        .irq_only_o (irq_only)
    );

    assign wr_ok     = reg_wr_i & ~take;
    assign status_wr = wr_ok & ~exc_return_i & (reg_addr_i == REG_STATUS);
    assign cause_wr  = wr_ok & (reg_addr_i == REG_CAUSE);
    assign savepc_wr = wr_ok & (reg_addr_i == REG_SAVEPC);

    exc_status_stack #(.MASK_W(MASK_W), .DEPTH(DEPTH)) stk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (take),
        .pop_i    (exc_return_i),
        .wr_i     (status_wr),
        .wmask_i  (reg_wdata_i[SW_LSB +: MASK_W]),
        .wstack_i (reg_wdata_i[STK_W-1:0]),
        .mask_o   (mask),
        .stack_o  (stack),
        .ie_o     (ie)
    );

    exc_cause_reg #(.N_IRQ(N_IRQ), .N_SW(N_SW)) cause_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .code_i     (arb_code),
        .bd_i       (in_delay_slot_i),
        .irq_i      (irq_i),
        .sw_wr_i    (cause_wr),
        .sw_wdata_i (reg_wdata_i[SW_LSB +: N_SW]),
        .bd_o       (bd),
        .ip_o       (ip),
        .sw_o       (sw),
        .code_o     (cur_code)
    );

    // ---- saved return address ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            savepc_q <= '0;
        end else if (take) begin
            savepc_q <= in_delay_slot_i ? (pc_i - XLEN'(4)) : pc_i;
        end else if (savepc_wr) begin
            savepc_q <= reg_wdata_i;
        end
    end

    // ---- register read ----
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            REG_STATUS: begin
                reg_rdata_o[SW_LSB +: MASK_W] = mask;
                reg_rdata_o[STK_W-1:0]        = stack;
            end
            REG_CAUSE: begin
                reg_rdata_o[XLEN-1]             = bd;
                reg_rdata_o[IP_LSB +: N_IRQ]    = ip;
                reg_rdata_o[SW_LSB +: N_SW]     = sw;
                reg_rdata_o[CODE_LSB +: 4]      = cur_code;
            end
            REG_SAVEPC: reg_rdata_o = savepc_q;
            default:    reg_rdata_o = '0;
        endcase
    end

    assert_redirect_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    assert_take_redirects_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redirect_o && (redirect_pc_o == HANDLER_PC));

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq_only) |-> ie && (mask != '0));

    assert_delay_slot_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_delay_slot_i) |=> (savepc_q == $past(pc_i) - XLEN'(4)) && bd);

    assert_vector_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VECTOR) |=> $stable(cur_code));

    assert_return_no_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return_i && !take && state_q == ST_RUN) |=> !redirect_o);
endmodule

// File: tb/exc_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module exc_ctrl_unit_tb_top;
    localparam real         HALF = 2.5;
    localparam logic [31:0] HANDLER = 32'h8000_0080;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc;
    logic        bdin, ld, st, ovf, ret, we;
    logic [5:0]  irq;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata, rpc;
    logic        redir;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model
    logic [7:0]  m_mask;
    logic [5:0]  m_stk;
    logic        m_bd;
    logic [5:0]  m_ip;
    logic [1:0]  m_sw;
    logic [3:0]  m_code;
    logic [31:0] m_pc;
    logic        m_vec;

    always #(HALF) clk = ~clk;

    exc_ctrl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc), .in_delay_slot_i(bdin),
        .ld_addr_err_i(ld), .st_addr_err_i(st), .ovf_i(ovf), .irq_i(irq),
        .exc_return_i(ret), .reg_wr_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .redirect_o(redir),
        .redirect_pc_o(rpc)
    );

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'd12:   return {16'h0, m_mask, 2'b00, m_stk};
            5'd13:   return {m_bd, 15'h0, m_ip, m_sw, 2'b00, m_code, 2'b00};
            5'd14:   return m_pc;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        pc = 32'h0; bdin = 0; ld = 0; st = 0; ovf = 0; ret = 0;
        we = 0; irq = '0; addr = 5'd12; wdata = '0;
    endtask

    // inputs set at negedge by caller; checks before the edge, model updates at the edge
    task automatic step(input string tag);
        logic take;
        #1;
        chk({tag, " redirect"}, {31'h0, redir}, {31'h0, m_vec});
        chk({tag, " redirect pc"}, rpc, m_vec ? HANDLER : 32'h0);
        chk({tag, " read"}, rdata, exp_read(addr));
        take = !m_vec && (ld || st || ovf || (m_stk[0] && (|({irq, m_sw} & m_mask))));
        @(posedge clk);
        m_ip = irq;
        if (take) begin
            m_code = ld ? 4'd4 : st ? 4'd5 : ovf ? 4'd12 : 4'd0;
            m_bd   = bdin;
            m_pc   = bdin ? pc - 32'd4 : pc;
            m_stk  = {m_stk[3:0], 2'b00};
            m_vec  = 1'b1;
        end else begin
            m_vec = 1'b0;
            if (ret) m_stk = {m_stk[5:4], m_stk[5:2]};
            else if (we && addr == 5'd12) begin
                m_mask = wdata[15:8];
                m_stk  = wdata[5:0];
            end
            if (we && addr == 5'd13) m_sw = wdata[9:8];
            if (we && addr == 5'd14) m_pc = wdata;
        end
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [4:0] a);
        idle_inputs();
        addr = a;
        step(tag);
    endtask

    task automatic wr(input string tag, input logic [4:0] a, input logic [31:0] d);
        idle_inputs();
        addr = a; we = 1; wdata = d;
        step(tag);
    endtask

    initial begin
        #(HALF * 2.0 * 200000.0);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        idle_inputs();
        rst_n = 0;
        m_mask = 0; m_stk = 0; m_bd = 0; m_ip = 0; m_sw = 0; m_code = 0; m_pc = 0; m_vec = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset values
        rd("R1 status", 5'd12);
        rd("R1 cause", 5'd13);
        rd("R1 savepc", 5'd14);

        // R8: writable fields and unmapped reads
        wr("R8 status write", 5'd12, 32'hFFFF_FFFF);
        rd("R8 status mask", 5'd12);
        wr("R8 status clear", 5'd12, 32'h0);
        wr("R8 cause write", 5'd13, 32'hFFFF_FFFF);
        rd("R8 cause sw only", 5'd13);
        wr("R8 cause clear", 5'd13, 32'h0);
        wr("R8 savepc write", 5'd14, 32'h1234_5678);
        rd("R8 savepc read", 5'd14);
        rd("R8 unmapped", 5'd3);

        // R6: enable set but mask clear -> no entry
        wr("R6 enable only", 5'd12, 32'h0000_0001);
        idle_inputs(); irq = 6'h3F; step("R6 masked irq");
        rd("R6 no entry", 5'd13);
        // mask only line 2 (bit 12), raise line 0 -> still none
        wr("R6 mask line2", 5'd12, 32'h0000_1001);
        idle_inputs(); irq = 6'b000001; step("R6 other line");
        rd("R6 still none", 5'd13);
        // now line 2 -> entry
        idle_inputs(); irq = 6'b000100; pc = 32'h0000_4000; step("R6 matching line");
        rd("R2 redirect and cause", 5'd13);
        rd("R2 savepc", 5'd14);
        rd("R4 stack pushed", 5'd12);

        // R5: return pops, no redirect
        idle_inputs(); ret = 1; addr = 5'd12; step("R5 return");
        rd("R5 stack popped", 5'd12);
        rd("R5 no redirect", 5'd14);

        // R3: priorities
        idle_inputs(); ld = 1; st = 1; ovf = 1; irq = 6'h3F; pc = 32'h100; step("R3 all faults");
        rd("R3 load code", 5'd13);
        idle_inputs(); st = 1; ovf = 1; pc = 32'h200; step("R3 store and ovf");
        rd("R3 store code", 5'd13);
        idle_inputs(); ovf = 1; pc = 32'h300; step("R3 ovf");
        rd("R3 ovf code", 5'd13);

        // R7: delay slot
        idle_inputs(); ovf = 1; bdin = 1; pc = 32'h0000_1000; step("R7 delay slot");
        rd("R7 savepc minus 4", 5'd14);
        rd("R7 bd flag", 5'd13);

        // R9: request during redirect cycle is ignored
        idle_inputs(); st = 1; pc = 32'h500; step("R9 first entry");
        idle_inputs(); ld = 1; pc = 32'h600; addr = 5'd13; step("R9 during vector");
        rd("R9 code kept", 5'd13);
        rd("R9 savepc kept", 5'd14);

        // R8: collisions
        idle_inputs(); ovf = 1; pc = 32'h700; we = 1; addr = 5'd14; wdata = 32'hDEAD_BEEF;
        step("R8 entry beats write");
        rd("R8 savepc from entry", 5'd14);
        wr("R8 set stack", 5'd12, 32'h0000_0034);
        idle_inputs(); ret = 1; we = 1; addr = 5'd12; wdata = 32'h0000_FF3F;
        step("R8 return beats write");
        rd("R8 stack from return", 5'd12);

        // random phase: status stack chains, software interrupts, collisions
        for (int i = 0; i < 4000; i++) begin
            int r;
            idle_inputs();
            pc    = {$urandom} & 32'hFFFF_FFFC;
            bdin  = ($urandom % 4) == 0;
            ld    = ($urandom % 12) == 0;
            st    = ($urandom % 12) == 0;
            ovf   = ($urandom % 12) == 0;
            irq   = (($urandom % 3) == 0) ? 6'($urandom) : 6'h0;
            ret   = ($urandom % 6) == 0;
            we    = ($urandom % 4) == 0;
            wdata = $urandom;
            r     = $urandom % 4;
            addr  = (r == 0) ? 5'd12 : (r == 1) ? 5'd13 : (r == 2) ? 5'd14 : 5'($urandom);
            step("R4 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule